// File: doc/BRIEF.md
# SPI Receive-Only Request and Word Packer

This unit controls receive-only transfers of an SPI master. Software writes a byte count into a request port. When the unit is idle and the count is nonzero, the count loads into a to-do counter. The unit then raises a run enable that keeps the serial clock going. While the clock runs, the shift engine sends idle data. Each byte that the shift engine delivers lowers the to-do count by one. When the count reaches zero, the run enable drops.

Received bytes are collected into 32-bit words. A word is handed to the receive path as soon as four bytes are present. When the transfer ends with fewer than four bytes collected, the leftover bytes are flushed as a final partial word. Every word carries a 3-bit byte-valid count. A consumer can therefore tell how many low-order lanes hold data. Within those lanes, the first byte received sits in the most significant valid lane.

Top module: `rxpk_unit`

## Requirements
- R1: A request write with a nonzero count, while the to-do count is zero, loads the count. `todo_count` shows it and `clk_run` is high from the next cycle.
- R2: A request write with a count of zero has no effect: `todo_count` stays zero and `clk_run` stays low.
- R3: A request write while the to-do count is nonzero is ignored. The to-do count follows only the received bytes.
- R4: Each byte accepted from the shift engine while the to-do count is nonzero lowers the count by exactly one in the next cycle. Bytes offered while the count is zero are discarded and produce no word.
- R5: `clk_run` is high exactly while the to-do count is nonzero. It falls in the cycle after the final byte is accepted, and that same cycle presents the flushed word.
- R6: In the cycle after the fourth byte of a group is accepted, `word_valid` is high for one cycle with `word_bytes` = 4 (a binary count). The group's first byte is in bits 31:24 and its last byte is in bits 7:0.
- R7: When a transfer ends with 1 to 3 bytes collected, one word is emitted in the cycle after the last byte. In that word, `word_bytes` equals the number of leftover bytes, which occupy the low-order lanes. The first-received byte is in the most significant valid lane and the unused upper lanes are zero. `word_bytes` is never 0 or above 4 while `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Request write strobe |
| req_count | input | 16 | Requested byte count |
| todo_count | output | 16 | Requested bytes not yet received |
| clk_run | output | 1 | Serial clock enable to the shift engine |
| rx_byte_valid | input | 1 | Shift engine delivers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| word_valid | output | 1 | Packed word present this cycle |
| word_data | output | 32 | Packed receive word |
| word_bytes | output | 3 | Number of valid low-order bytes in `word_data` (1..4) |

## Verification
The hardest situations to reach from the ports are request writes and stray bytes that arrive during a busy transfer, or just as it ends. A correctly behaved host never produces them. The stimulus mixes random byte gaps with random request writes in every byte slot of a transfer. It also feeds bytes while the unit is idle. This covers both the ignored-request path and the discard path. Lengths of 1, 3, 4, 5 and 8 are directed at the flush boundaries. Random lengths cover every remainder modulo four.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int BYTE_W = 8;

  // Number of bits needed to hold a value from 0 up to n.
  function automatic int count_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rxpk_todo.sv
module rxpk_todo #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_we,
  input  logic [CNT_W-1:0] req_count,
  input  logic             byte_in,
  output logic [CNT_W-1:0] todo,
  output logic             run,
  output logic             take,
  output logic             last
);
  logic load;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign load = req_we && (todo == '0) && (req_count != '0);
  assign take = byte_in && (todo != '0);
  assign last = take && (todo == CNT_W'(1));
  assign run  = (todo != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    todo <= '0;
    else if (load) todo <= req_count;
    else if (take) todo <= step_down(todo);
  end

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> todo == $past(req_count)); // R1
  AST_ZERO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (todo == '0) && !(req_we && req_count != '0) |=> todo == '0); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (todo != '0) && req_we && !byte_in |=> $stable(todo)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> todo == $past(todo) - CNT_W'(1)); // R4
endmodule

// File: rtl/rxpk_packer.sv
module rxpk_packer
  import rxpk_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int NB_W       = 3,
  localparam int WORD_W    = WORD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last,
  input  logic [BYTE_W-1:0] din,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [NB_W-1:0]   out_bytes
);
  logic [WORD_W-1:0] acc;
  logic [NB_W-1:0]   fill;
  logic [WORD_W-1:0] acc_nx;
  logic [NB_W-1:0]   fill_nx;
  logic              lane_full;
  logic              emit;

  // Append a byte at the low end: the oldest byte moves toward the top lane.
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    return {a[WORD_W-BYTE_W-1:0], b};
  endfunction

  assign acc_nx    = shift_in(acc, din);
  assign fill_nx   = fill + NB_W'(1);
  assign lane_full = (fill == NB_W'(WORD_BYTES - 1));
  assign emit      = take && (lane_full || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bytes <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_data  <= acc_nx;
        out_bytes <= fill_nx;
        acc       <= '0;
        fill      <= '0;
      end else if (take) begin
        acc  <= acc_nx;
        fill <= fill_nx;
      end
    end
  end

  AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    take && lane_full |=> out_valid && out_bytes == NB_W'(WORD_BYTES)); // R6
  AST_NB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes != '0) && (out_bytes <= NB_W'(WORD_BYTES))); // R7
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !out_valid); // R6
endmodule

// File: rtl/rxpk_unit.sv
module rxpk_unit
  import rxpk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int NB_W      = count_w(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [CNT_W-1:0]  req_count,
  output logic [CNT_W-1:0]  todo_count,
  output logic              clk_run,
  input  logic              rx_byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [NB_W-1:0]   word_bytes
);
  logic byte_take;
  logic byte_last;

  rxpk_todo #(.CNT_W(CNT_W)) u_todo (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_we    (req_we),
    .req_count (req_count),
    .byte_in   (rx_byte_valid),
    .todo      (todo_count),
    .run       (clk_run),
    .take      (byte_take),
    .last      (byte_last)
  );

  rxpk_packer #(.WORD_BYTES(WORD_BYTES), .NB_W(NB_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (byte_take),
    .last      (byte_last),
    .din       (rx_byte),
    .out_valid (word_valid),
    .out_data  (word_data),
    .out_bytes (word_bytes)
  );

  AST_RUN_STOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run) |-> word_valid); // R5
  AST_PARTIAL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && (word_bytes != NB_W'(WORD_BYTES)) |-> !clk_run); // R7
  AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |=> !word_valid); // R4
endmodule

// File: tb/sim_rxpk_unit.sv
module sim_rxpk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_count = '0;
  logic [15:0] todo_count;
  logic        clk_run;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        word_valid;
  logic [31:0] word_data;
  logic [2:0]  word_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_data_q[$];
  logic [2:0]  exp_nb_q[$];

  always #4 clk = ~clk;

  rxpk_unit u0 (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model: k bytes starting at index s, first byte goes highest among the valid lanes.
  function automatic logic [31:0] model_word(input logic [7:0] b[$], input int s, input int k);
    logic [31:0] w = '0;
    for (int i = 0; i < k; i++) w = w | (32'(b[s+i]) << (8 * (k - 1 - i)));
    return w;
  endfunction

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R4 unexpected word", word_data, 0);
      end else begin
        logic [31:0] ed;
        logic [2:0]  en;
        ed = exp_data_q.pop_front();
        en = exp_nb_q.pop_front();
        check(word_data == ed, (en == 3'd4) ? "R6 data" : "R7 data", word_data, ed);
        check(word_bytes == en, (en == 3'd4) ? "R6 bytes" : "R7 bytes", word_bytes, en);
      end
    end
  end

  task automatic run_xfer(input int n, input int gap_pct, input int junk_pct);
    logic [7:0] bq[$];
    int left;
    for (int i = 0; i < n; i++) bq.push_back(8'($urandom));
    for (int s = 0; s < n; s += 4) begin
      int k = (n - s >= 4) ? 4 : n - s;
      exp_data_q.push_back(model_word(bq, s, k));
      exp_nb_q.push_back(3'(k));
    end
    @(negedge clk);
    req_we = 1'b1; req_count = 16'(n);
    @(negedge clk);
    req_we = 1'b0;
    check(todo_count == 16'(n), "R1 load", todo_count, n);
    check(clk_run == 1'b1, "R1 run", clk_run, 1);
    left = n;
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        if (($urandom % 100) < junk_pct) begin req_we = 1'b1; req_count = 16'($urandom); end
        @(negedge clk);
        req_we = 1'b0;
        check(todo_count == 16'(left), "R3 busy request ignored", todo_count, left);
      end
      rx_byte_valid = 1'b1; rx_byte = bq[i];
      if (($urandom % 100) < junk_pct) begin req_we = 1'b1; req_count = 16'($urandom); end
      @(negedge clk);
      rx_byte_valid = 1'b0; req_we = 1'b0;
      left--;
      check(todo_count == 16'(left), "R4 step", todo_count, left);
      check(clk_run == (left != 0), "R5 run", clk_run, left != 0);
    end
    @(negedge clk);
    check(exp_data_q.size() == 0, "R5 flush done", exp_data_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(todo_count == 0 && !clk_run && !word_valid, "R1 reset", todo_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    req_we = 1'b1; req_count = 16'd0;
    @(negedge clk);
    req_we = 1'b0;
    check(todo_count == 0, "R2 zero request", todo_count, 0);
    check(clk_run == 1'b0, "R2 zero request run", clk_run, 0);
    for (int i = 0; i < 4; i++) begin
      rx_byte_valid = 1'b1; rx_byte = 8'($urandom);
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    @(negedge clk);
    check(todo_count == 0, "R4 idle bytes discarded", todo_count, 0);
    check(exp_data_q.size() == 0, "R4 idle no word", exp_data_q.size(), 0);
    run_xfer(1, 0, 0);
    run_xfer(3, 0, 0);
    run_xfer(4, 0, 0);
    run_xfer(5, 30, 50);
    run_xfer(8, 0, 100);
    for (int t = 0; t < 24; t++) run_xfer(1 + int'($urandom % 40), 25, 20);
    run_xfer(200, 10, 10);
    for (int i = 0; i < 3; i++) begin
      rx_byte_valid = 1'b1; rx_byte = 8'hA5;
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    @(negedge clk);
    check(todo_count == 0 && !clk_run, "R4 post-transfer bytes discarded", todo_count, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule